// File: doc/BRIEF.md
# Boxcar Averager with Start-up Flush

This block keeps a running mean of the last sixteen accepted input samples. A shift-register delay line holds the window. A running-sum register adds each new sample and, in the same cycle, takes away the sample that drops out of the far end of the window. The output is that sum divided by sixteen, truncated. It comes with a flag that pulses one cycle after every accepted sample.

The delay line is built from registers that have no reset, so after reset it may still hold stale values. Reset therefore clears only the running sum and the control. A controller then pushes zeros through the whole delay line for sixteen cycles before it accepts any data. While this happens, `busy` is high, inputs are ignored and no output is flagged valid. When the flush is done, the window agrees with the zero sum, and the average carries no offset from earlier contents.

The controller has two states:
- `ST_FLUSH` is entered on reset. It shifts zeros and counts sixteen cycles.
- `ST_RUN` is where normal averaging happens.

There are two transitions. The first, `flush_done`, goes from `ST_FLUSH` to `ST_RUN` on the sixteenth flush cycle. The second is `reset_entry`, which returns from any state to `ST_FLUSH` when `rst_n` is asserted.

Top module: `boxcar_avg`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and `busy` is 1.
- R2: After `rst_n` goes high, `busy` stays high for exactly 16 clock cycles and then stays low until the next reset.
- R3: While `busy` is high, `in_valid` and `in_data` are ignored: `out_valid` stays 0, and the first average after the flush includes no sample offered during the flush.
- R4: After a reset, stale delay-line contents from before the reset do not affect any later average, because the flush shifts 16 zeros through the window.
- R5: When `in_valid` is 1 and `busy` is 0, the sample is accepted. The running sum gains the new sample and loses the sample accepted 16 acceptances earlier (zero if fewer than 16 have been accepted since the flush), both in the same cycle.
- R6: `out_data` equals the running sum shifted right by 4 bits (floor of sum/16).
- R7: `out_valid` is 1 in the cycle after an accepted sample and 0 in the cycle after any cycle with no accepted sample.
- R8: The running sum is DATA_W+4 bits wide, so it never wraps. Sixteen consecutive samples of 255 (DATA_W=8) give `out_data` = 255.
- R9: `out_data` holds its value in any cycle that follows a cycle with no accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | DATA_W | Unsigned input sample |
| out_valid | output | 1 | Pulses one cycle after each accepted sample |
| out_data | output | DATA_W | Truncated mean of the window |
| busy | output | 1 | High while the delay line is being flushed |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and WIN_LOG2 = 4, which gives a window of 16 and a 12-bit sum. This 8-bit width makes an all-255 window the exact top of the sum's range, so the no-wrap case can be reached with a short directed burst. A window of 16 lets a mid-run reset land while the delay line is full of nonzero data. That makes any offset left by a missing or short flush visible in the first average afterwards.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

    // Controller states: zero-flush of the window, then normal averaging
    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } avg_state_e;

endpackage

// File: rtl/boxcar_ctrl.sv
module boxcar_ctrl
    import boxcar_pkg::*;
#(
    parameter int WIN_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic busy,
    output logic shift_en,
    output logic shift_zero,
    output logic accept
);

    localparam int                  WIN     = 1 << WIN_LOG2;
    localparam logic [WIN_LOG2-1:0] LAST_IX = WIN_LOG2'(WIN - 1);

    avg_state_e          state_q, state_d;
    logic [WIN_LOG2-1:0] flush_cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: if (flush_cnt_q == LAST_IX) state_d = ST_RUN;   // flush_done
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_FLUSH;
        endcase
    end

    // state register and flush counter (reset_entry)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_FLUSH;
            flush_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FLUSH)
                flush_cnt_q <= flush_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        shift_en   = 1'b0;
        shift_zero = 1'b0;
        accept     = 1'b0;
        unique case (state_q)
            ST_FLUSH: begin
                busy       = 1'b1;
                shift_en   = 1'b1;
                shift_zero = 1'b1;
            end
            ST_RUN: begin
                shift_en = in_valid;
                accept   = in_valid;
            end
            default: busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/boxcar_delay.sv
module boxcar_delay #(
    parameter int DATA_W   = 8,
    parameter int WIN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              shift_zero,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] tail
);

    localparam int DEPTH = 1 << WIN_LOG2;

    // storage deliberately has no reset; the controller flushes it
    logic [DATA_W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (shift_en)
            stage_q[0] <= shift_zero ? '0 : din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (shift_en)
                stage_q[g] <= stage_q[g-1];
        end
    end

    assign tail = stage_q[DEPTH-1];

endmodule

// File: rtl/boxcar_acc.sv
module boxcar_acc #(
    parameter int DATA_W   = 8,
    parameter int WIN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] tail,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int ACC_W = DATA_W + WIN_LOG2;

    logic [ACC_W-1:0] sum_q;
    logic             vld_q;

    // subtraction only happens on accepted samples, never during the flush
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= accept;
            if (accept)
                sum_q <= sum_q + ACC_W'(din) - ACC_W'(tail);
        end
    end

    assign out_valid = vld_q;
    assign out_data  = sum_q[ACC_W-1:WIN_LOG2];

endmodule

// File: rtl/boxcar_avg.sv
module boxcar_avg #(
    parameter int DATA_W   = 8,
    parameter int WIN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              busy
);

    logic              shift_en;
    logic              shift_zero;
    logic              accept;
    logic [DATA_W-1:0] tail;

    boxcar_ctrl #(.WIN_LOG2(WIN_LOG2)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .busy       (busy),
        .shift_en   (shift_en),
        .shift_zero (shift_zero),
        .accept     (accept)
    );

    boxcar_delay #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_delay (
        .clk        (clk),
        .shift_en   (shift_en),
        .shift_zero (shift_zero),
        .din        (in_data),
        .tail       (tail)
    );

    boxcar_acc #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .din       (in_data),
        .tail      (tail),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/boxcar_avg_chk.sv
module boxcar_avg_chk #(
    parameter int DATA_W   = 8,
    parameter int WIN_LOG2 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              busy,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    localparam int                  WIN = 1 << WIN_LOG2;
    localparam logic [WIN_LOG2:0]   WIN_CNT = (WIN_LOG2+1)'(WIN);

    logic [WIN_LOG2:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_cnt_q <= '0;
        else if (busy)
            busy_cnt_q <= busy_cnt_q + 1'b1;
    end

    assert_flush_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt_q == WIN_CNT);

    assert_flush_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt_q <= WIN_CNT);

    assert_quiet_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> out_valid);

    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !busy) |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !busy) |=> $stable(out_data));

endmodule

bind boxcar_avg boxcar_avg_chk #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_boxcar_avg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_boxcar_avg.sv
`timescale 1ns/1ps
module test_boxcar_avg;

    localparam int DATA_W = 8;
    localparam int WIN    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              busy;

    int n_checks = 0;
    int n_errors = 0;

    int hist [WIN];
    int sum_m;

    always #5 clk = ~clk;

    boxcar_avg #(.DATA_W(DATA_W), .WIN_LOG2(4)) i_boxcar_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .busy      (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expected_avg();
        return sum_m / WIN;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < WIN; i++) hist[i] = 0;
        sum_m = 0;
    endfunction

    function automatic void model_push(input int d);
        sum_m = sum_m + d - hist[WIN-1];
        for (int i = WIN-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = d;
    endfunction

    // one cycle in run mode; inputs change and outputs are sampled at negedge
    task automatic step(input logic v, input int d, input string req);
        in_valid = v;
        in_data  = DATA_W'(d);
        @(posedge clk);
        @(negedge clk);
        if (v) model_push(d);
        check({req, " out_valid"}, int'(out_valid), int'(v));
        check({req, " out_data"}, int'(out_data), expected_avg());
    endtask

    // reset release plus flush, with junk samples offered while busy
    task automatic reset_and_flush();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_data  = 8'hA5;
        repeat (2) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        check("R1 busy in reset", int'(busy), 1);
        rst_n = 1'b1;
        model_clear();
        for (int k = 0; k <= WIN; k++) begin
            in_valid = (k < WIN);
            in_data  = DATA_W'(8'hC3 + k);
            check("R2 busy window", int'(busy), (k < WIN) ? 1 : 0);
            check("R3 no valid while busy", int'(out_valid), 0);
            if (k < WIN) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        step(1'b0, 0, "R3 sum untouched by flush-time inputs");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        @(negedge clk);
        reset_and_flush();

        // R5/R6: ramp fills and then slides the window
        for (int i = 1; i <= 24; i++) step(1'b1, i * 7, "R5 R6 ramp");

        // R7/R9: gaps hold the average and drop the valid flag
        for (int i = 0; i < 4; i++) step(1'b0, 99, "R7 R9 gap");

        // R8: full-scale window reaches 255 without wrap
        for (int i = 0; i < WIN; i++) step(1'b1, 255, "R8 full scale");
        check("R8 max average", int'(out_data), 255);

        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic v;
            int   d;
            v = ($urandom_range(9, 0) < 7);
            d = int'($urandom_range(255, 0));
            if ((i % 50) < 5) d = (i % 2) ? 255 : 0;
            step(v, d, "R5 R6 R7 R9 random");
        end

        // R4: window full of stale nonzero data, then reset mid-run
        for (int i = 0; i < WIN; i++) step(1'b1, 200, "R4 preload");
        reset_and_flush();
        step(1'b1, 32, "R4 first sample after flush");
        check("R4 no stale offset", int'(out_data), 2);
        for (int i = 0; i < 20; i++) step(1'b1, 16, "R4 refill");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule